// File: doc/BRIEF.md
# CAN Buffer and Error Interrupt Controller

This block gathers the interrupt sources of a CAN controller with fifteen message buffers and one error source into a single level-sensitive interrupt request. Each buffer reports a completed transmission or reception with a one-cycle pulse. The controller latches that pulse into a sticky pending flag. An error flag is latched whenever the receive or the transmit error counter shows a value different from the one it held on the previous clock.

Software reaches the controller through a small register port with three addresses. An enable register (read/write) selects which sources may raise the request. A pending register (read-only) shows the latched flags. A clear register (write-only, reads as zero) drops the pending flags whose bits are written as 1. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `can_irq_ctrl`

## Requirements
- R1: After reset the enable register and the pending register read 0, and `irq` is low.
- R2: A write to address 0 loads the enable register, and a read at address 0 returns it. Bit n (0..14) enables buffer n, and bit 15 enables the error source.
- R3: A high on `buf_done[n]` at a rising clock edge sets pending bit n, visible from that edge on.
- R4: Pending bit 15 is set at any edge where `rec_cnt` or `tec_cnt` differs from its value at the previous edge. The held copy starts at 0 after reset. A counter that holds steady sets nothing.
- R5: A write to address 2 clears every pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R6: When a set event and a clear of the same pending bit fall on the same edge, the bit ends up set.
- R7: The pending register at address 1 is read-only, so a write there changes nothing. A read at address 2 returns 0.
- R8: `irq` is high exactly when some bit is 1 in both the pending and the enable registers. With enable bit 15 at 0, a pending error raises no request.
- R9: A pending bit stays set until it is cleared through address 2, whatever the source inputs do in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_done | input | 15 | Per-buffer success pulses, bit n for buffer n |
| rec_cnt | input | 8 | Current receive error counter value |
| tec_cnt | input | 8 | Current transmit error counter value |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 enable, 1 pending, 2 clear |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from `bus_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives a buffer pulse and a clear of the same bit on one edge. A design that let the clear win would lose that event, and the bit would read 0. It changes each error counter on its own and then holds it steady. A design that compared against a stale copy, or that watched only one counter, would either miss the set or raise error pending again with no change. It writes to the pending address and clears with partial masks. A writable pending register, or a clear that acted on the 0 bits, shows up as flags that change when they should not. It also raises error pending while the error enable is 0 and checks that `irq` stays low.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE  = 2'd0,
    REG_PENDING = 2'd1,
    REG_CLEAR   = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/can_irq_chg_det.sv
module can_irq_chg_det #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rec_cnt,
  input  logic [CNT_W-1:0] tec_cnt,
  output logic             changed
);
  logic [CNT_W-1:0] rec_q, tec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
      tec_q <= '0;
    end else begin
      rec_q <= rec_cnt;
      tec_q <= tec_cnt;
    end
  end

  assign changed = (rec_cnt != rec_q) || (tec_cnt != tec_q);

  // R4: the copies always follow the inputs one edge later
  p_copy_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rec_q == $past(rec_cnt)) && (tec_q == $past(tec_cnt)));
endmodule

// File: rtl/can_irq_pend.sv
module can_irq_pend #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_o[i] <= 1'b0;
      else if (set_i[i]) pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> pend_o[i]);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_o[i] && !set_i[i]) |=> !pend_o[i]);
  end
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
  import can_irq_pkg::*;
#(
  parameter int NUM_BUF = 15,
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_BUF-1:0] buf_done,
  input  logic [CNT_W-1:0]  rec_cnt,
  input  logic [CNT_W-1:0]  tec_cnt,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int REG_W = NUM_BUF + 1;
  localparam int ERR_B = NUM_BUF;

  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] pend;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic             err_chg;

  can_irq_chg_det #(.CNT_W(CNT_W)) u_chg (
    .clk     (clk),
    .rst_n   (rst_n),
    .rec_cnt (rec_cnt),
    .tec_cnt (tec_cnt),
    .changed (err_chg)
  );

  assign set_vec = {err_chg, buf_done};
  assign clr_vec = (bus_wr && bus_addr == REG_CLEAR) ? bus_wdata[REG_W-1:0] : '0;

  can_irq_pend #(.W(REG_W)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .pend_o (pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              en_q <= '0;
    else if (bus_wr && bus_addr == REG_ENABLE) en_q <= bus_wdata[REG_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_ENABLE:  bus_rdata[REG_W-1:0] = en_q;
      REG_PENDING: bus_rdata[REG_W-1:0] = pend;
      default:     bus_rdata = '0;
    endcase
  end

  assign irq = |(pend & en_q);

  // R8: nothing enabled means no request
  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
  // R8: an error-only pending with error disabled raises nothing
  p_err_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[ERR_B] && pend == (REG_W'(1) << ERR_B)) |-> !irq);
  // R7: the clear address always reads back as zero
  p_clr_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_CLEAR) |-> (bus_rdata == '0));
endmodule

// File: tb/can_irq_ctrl_test.sv
module can_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] buf_done = '0;
  logic [7:0]  rec_cnt = '0;
  logic [7:0]  tec_cnt = '0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  can_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .buf_done(buf_done), .rec_cnt(rec_cnt),
    .tec_cnt(tec_cnt), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [14:0] m);
    buf_done = m;
    @(negedge clk);
    buf_done = '0;
  endtask

  task automatic clear_all();
    reg_write(2'd2, 16'hFFFF);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    reg_read(2'd0, d); check("R1 enable", d, 16'h0);
    reg_read(2'd1, d); check("R1 pending", d, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_enable();
    logic [15:0] d;
    reg_write(2'd0, 16'hA5C3);
    reg_read(2'd0, d); check("R2 enable readback", d, 16'hA5C3);
    reg_write(2'd0, 16'h0000);
    reg_read(2'd0, d); check("R2 enable zero", d, 16'h0000);
  endtask

  task automatic t_buf_set();
    logic [15:0] d;
    pulse(15'h0001);
    reg_read(2'd1, d); check("R3 buffer 0", d, 16'h0001);
    pulse(15'h4000);
    reg_read(2'd1, d); check("R3 buffer 14", d, 16'h4001);
    pulse(15'h0A50);
    reg_read(2'd1, d); check("R3 multi", d, 16'h4A51);
    repeat (3) @(negedge clk);
    reg_read(2'd1, d); check("R9 sticky", d, 16'h4A51);
    clear_all();
  endtask

  task automatic t_err_change();
    logic [15:0] d;
    rec_cnt = 8'd5;
    @(negedge clk);
    reg_read(2'd1, d); check("R4 rec change", d, 16'h8000);
    clear_all();
    reg_read(2'd1, d); check("R4 steady rec sets nothing", d, 16'h0000);
    @(negedge clk);
    reg_read(2'd1, d); check("R4 still steady", d, 16'h0000);
    tec_cnt = 8'd1;
    @(negedge clk);
    reg_read(2'd1, d); check("R4 tec change", d, 16'h8000);
    clear_all();
    rec_cnt = 8'd4;
    @(negedge clk);
    reg_read(2'd1, d); check("R4 rec decrement", d, 16'h8000);
    clear_all();
  endtask

  task automatic t_clear_mask();
    logic [15:0] d;
    pulse(15'h00FF);
    reg_write(2'd2, 16'h000F);
    reg_read(2'd1, d); check("R5 partial clear", d, 16'h00F0);
    reg_write(2'd2, 16'h0000);
    reg_read(2'd1, d); check("R5 zero write no effect", d, 16'h00F0);
    clear_all();
    reg_read(2'd1, d); check("R5 full clear", d, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    pulse(15'h0010);
    buf_done = 15'h0008;
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 16'h0018;
    @(negedge clk);
    buf_done = '0; bus_wr = 1'b0; bus_wdata = '0;
    reg_read(2'd1, d); check("R6 set beats clear", d, 16'h0008);
    clear_all();
  endtask

  task automatic t_readonly();
    logic [15:0] d;
    pulse(15'h0002);
    reg_write(2'd1, 16'h0000);
    reg_read(2'd1, d); check("R7 pending write ignored (clear try)", d, 16'h0002);
    reg_write(2'd1, 16'hFFFF);
    reg_read(2'd1, d); check("R7 pending write ignored (set try)", d, 16'h0002);
    reg_read(2'd2, d); check("R7 clear reads zero", d, 16'h0000);
    reg_read(2'd0, d); check("R7 enable untouched", d, 16'h0000);
    clear_all();
  endtask

  task automatic t_irq();
    logic [15:0] d;
    reg_write(2'd0, 16'h7FFF);
    rec_cnt = 8'd9;
    @(negedge clk);
    reg_read(2'd1, d); check("R8 err pending", d, 16'h8000);
    check("R8 err masked irq low", {15'd0, irq}, 16'h0);
    reg_write(2'd0, 16'h8000);
    check("R8 err enabled irq high", {15'd0, irq}, 16'h1);
    clear_all();
    check("R8 irq drops after clear", {15'd0, irq}, 16'h0);
    reg_write(2'd0, 16'h0004);
    pulse(15'h0002);
    check("R8 other buffer no irq", {15'd0, irq}, 16'h0);
    pulse(15'h0004);
    check("R8 enabled buffer irq", {15'd0, irq}, 16'h1);
    reg_write(2'd2, 16'h0004);
    check("R8 irq low after clear", {15'd0, irq}, 16'h0);
    reg_write(2'd0, 16'h0000);
    clear_all();
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_buf_set();
    t_err_change();
    t_clear_mask();
    t_collision();
    t_readonly();
    t_irq();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule